// File: doc/BRIEF.md
# Pin Event Capture and Interrupt

This block watches a word of pin input values and records events on each pin in a sticky status word. Each pin is set up either for level detection, where the status bit is set on every clock that the input is high, or for edge detection. An edge pin captures only rising transitions, or both rising and falling transitions. Software clears status bits by writing ones to the bits it wants cleared. Bits written as zero keep their value.

The status word is ANDed with a per-pin enable vector. Any bit set in the result drives a single level-sensitive interrupt. The enable vector only masks the interrupt. Status keeps latching while a pin's enable is low, so enabling that pin later raises the interrupt at once.

The block sits between pad resolution logic and a register file. Both of those are outside it. The block takes the resolved input word, the configuration vectors and a one-cycle clear strobe with its mask.

Top module: `pin_evt_irq`

## Requirements
- R1: A pin whose type bit is 0 (level) sets its status bit on the clock edge after its input is sampled high. The bit stays set after the input falls.
- R2: A pin whose type bit is 1 (edge) and whose both-edge bit is 0 sets its status bit only on a 0-to-1 change of its input between consecutive clocks. A 1-to-0 change leaves the bit unchanged.
- R3: A pin whose type bit is 1 and whose both-edge bit is 1 sets its status bit on a 0-to-1 change and also on a 1-to-0 change.
- R4: While the clear strobe is high, each status bit whose mask bit is 1 is cleared on the next clock. Bits whose mask bit is 0 keep their value. Without a clear, set bits stay set.
- R5: A level pin whose input is still high cannot be cleared. It reads back as set after the clear.
- R6: When a clear and a new event hit the same bit in the same cycle, the bit ends up set.
- R7: The interrupt output is a register that holds the OR of (status AND enable) from the previous clock. Clearing an enable bit drops it one clock later, and setting it again raises it one clock later.
- R8: Status bits latch while their enable is 0, and the interrupt stays low during that time.
- R9: After reset, status and interrupt are 0. Inputs that are already high when reset is released create no edge event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| din_i | input | NPINS | Resolved pin input values |
| evt_edge_i | input | NPINS | Per-pin type: 0 level, 1 edge |
| evt_both_i | input | NPINS | Per-pin edge mode: 0 rising only, 1 both edges |
| evt_en_i | input | NPINS | Per-pin interrupt enable |
| clr_we_i | input | 1 | Clear strobe, one cycle per write |
| clr_mask_i | input | NPINS | Write-one-to-clear mask |
| status_o | output | NPINS | Sticky event status |
| irq_o | output | 1 | Registered interrupt |

## Verification
There are two pieces of internal state: the previous-input register and the status bits. If the previous-input register is wrong, the status word shows a spurious or missing edge bit on the clock right after the input change. One visible case is a bit set straight after reset while inputs are held high. If a status bit is wrong, it shows on status_o at the next clock edge. It then reaches irq_o one clock later, but only if that pin is enabled. For this reason the interrupt checks are always paired with enable changes made while status is stable.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;
  typedef enum logic {
    EVT_LEVEL = 1'b0,
    EVT_EDGE  = 1'b1
  } evt_kind_e;

  function automatic logic pin_hit(input logic cur, input logic prev, input logic armed,
                                   input logic is_edge, input logic both);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (evt_kind_e'(is_edge) == EVT_LEVEL) return cur;
    return armed & (rise | (both & fall));
  endfunction
endpackage

// File: rtl/pin_evt_detect.sv
module pin_evt_detect
  import pin_evt_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] din_i,
  input  logic [NPINS-1:0] evt_edge_i,
  input  logic [NPINS-1:0] evt_both_i,
  output logic [NPINS-1:0] hit_o
);
  logic [NPINS-1:0] din_q;
  logic             armed_q;

  // previous-value register tracks the input even in reset; edges gated until armed
  always_ff @(posedge clk_i) din_q <= din_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign hit_o[g] = pin_hit(din_i[g], din_q[g], armed_q, evt_edge_i[g], evt_both_i[g]);
  end

  // R2: rising-only edge pins never report on a low input
  p_no_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o & evt_edge_i & ~evt_both_i & ~din_i) == '0);
endmodule

// File: rtl/pin_evt_status.sv
module pin_evt_status #(
  parameter int NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] hit_i,
  input  logic             clr_we_i,
  input  logic [NPINS-1:0] clr_mask_i,
  output logic [NPINS-1:0] status_o
);
  logic [NPINS-1:0] st_q, clr_eff;

  assign clr_eff = clr_we_i ? clr_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= (st_q & ~clr_eff) | hit_i;  // new event beats clear
  end

  assign status_o = st_q;

  p_set_only_on_hit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q & ~$past(st_q) & ~$past(hit_i)) == '0));
  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((($past(st_q) & ~($past(clr_we_i) ? $past(clr_mask_i) : '0)) & ~st_q) == '0));
  p_event_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hit_i != '0) |=> ((st_q & $past(hit_i)) == $past(hit_i))));
endmodule

// File: rtl/pin_evt_irq.sv
module pin_evt_irq #(
  parameter int NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] din_i,
  input  logic [NPINS-1:0] evt_edge_i,
  input  logic [NPINS-1:0] evt_both_i,
  input  logic [NPINS-1:0] evt_en_i,
  input  logic             clr_we_i,
  input  logic [NPINS-1:0] clr_mask_i,
  output logic [NPINS-1:0] status_o,
  output logic             irq_o
);
  logic [NPINS-1:0] hit;
  logic             irq_q;

  pin_evt_detect #(.NPINS(NPINS)) i_detect (
    .clk_i, .rst_ni, .din_i, .evt_edge_i, .evt_both_i, .hit_o(hit)
  );

  pin_evt_status #(.NPINS(NPINS)) i_status (
    .clk_i, .rst_ni, .hit_i(hit), .clr_we_i, .clr_mask_i, .status_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status_o & evt_en_i);
  end

  assign irq_o = irq_q;

  p_irq_follows_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(status_o & evt_en_i)));
  p_masked_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_en_i == '0) |=> !irq_o);
endmodule

// File: tb/test_pin_evt_irq.sv
module test_pin_evt_irq;
  localparam int N = 32;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [N-1:0] din_i = '0, evt_edge_i = '0, evt_both_i = '0, evt_en_i = '0, clr_mask_i = '0;
  logic clr_we_i = 1'b0;
  logic [N-1:0] status_o;
  logic irq_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  pin_evt_irq #(.NPINS(N)) i_pin_evt_irq (.*);

  task automatic step(int k = 1);
    repeat (k) begin @(posedge clk_i); @(negedge clk_i); end
  endtask

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear(logic [N-1:0] m);
    clr_we_i = 1'b1; clr_mask_i = m; step(); clr_we_i = 1'b0; clr_mask_i = '0;
  endtask

  task automatic t_reset;
    din_i = 32'hFFFF0000; evt_edge_i = '1; evt_both_i = '0;
    step(2); rst_ni = 1'b1; step(3);
    chk("R9 status after reset", status_o, '0);
    chk("R9 irq after reset", {31'd0, irq_o}, '0);
  endtask

  task automatic t_rising;
    din_i = 32'hFF00FF00; step();
    chk("R2 first rise", status_o, 32'h0000FF00);
    din_i = 32'h00FF0000; step();
    chk("R2 falls ignored", status_o, 32'h00FFFF00);
    clear('0);
    chk("R4 zero mask no effect", status_o, 32'h00FFFF00);
    clear(32'h0000F000);
    chk("R4 partial clear", status_o, 32'h00FF0F00);
    clear(32'h00FF0F00);
    chk("R4 full clear", status_o, '0);
  endtask

  task automatic t_both;
    evt_both_i = '1; din_i = 32'hFFFF0000; step(2); clear('1);
    din_i = 32'hFF00FF00; step();
    chk("R3 both edges", status_o, 32'h00FFFF00);
    din_i = 32'hEF00FF08; step();
    chk("R3 fall and rise", status_o, 32'h10FFFF08);
    evt_both_i = '0; clear('1);
  endtask

  task automatic t_level;
    evt_edge_i = '0; din_i = 32'hBA987654; step();
    chk("R1 level capture", status_o, 32'hBA987654);
    din_i = '0; step();
    chk("R1 sticky after input low", status_o, 32'hBA987654);
    clear(32'h00007654);
    chk("R4 level clear", status_o, 32'hBA980000);
    din_i = 32'h00000001; step();
    clear(32'h00000001);
    chk("R5 level relatches while high", status_o, 32'hBA980001);
    din_i = '0; step(); clear('1);
    chk("R4 level cleared", status_o, '0);
  endtask

  task automatic t_collide;
    evt_edge_i = '1; evt_both_i = '0; din_i = '0; step(2); clear('1);
    din_i = 32'h2; step(); din_i = '0; step();
    chk("R6 setup", status_o, 32'h2);
    din_i = 32'h2; clr_we_i = 1'b1; clr_mask_i = 32'h2; step();
    clr_we_i = 1'b0; clr_mask_i = '0;
    chk("R6 event beats clear", status_o, 32'h2);
    clear(32'h2);
    chk("R6 later clear works", status_o, '0);
  endtask

  task automatic t_irq;
    evt_edge_i = '0; evt_en_i = '0; din_i = 32'h00008000; step(3);
    chk("R8 latched while disabled", status_o, 32'h00008000);
    chk("R8 irq low while disabled", {31'd0, irq_o}, '0);
    evt_en_i = '1; #1;
    chk("R7 irq registered not yet", {31'd0, irq_o}, '0);
    step();
    chk("R8 enable raises irq", {31'd0, irq_o}, 32'd1);
    evt_en_i = ~32'h00008000; step();
    chk("R7 mask drops irq", {31'd0, irq_o}, '0);
    evt_en_i = '1; step();
    chk("R7 unmask restores irq", {31'd0, irq_o}, 32'd1);
    din_i = '0; clear('1); step();
    chk("R7 irq low after clear", {31'd0, irq_o}, '0);
  endtask

  initial begin
    t_reset(); t_rising(); t_both(); t_level(); t_collide(); t_irq();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule